// File: doc/BRIEF.md
# Receive-Only Request Controller

This block drives a serial receiver that runs with no transmit data. Software writes a byte count, and the block then enables shift-clock generation. It samples one serial bit on each baud tick and packs the bits into 32-bit words for a receive FIFO. A 16-bit counter holds the number of bytes still outstanding, and it counts down by one for each completed byte.

Words are always 32 bits wide; no word-length setting applies. When fewer than four bytes remain, the request ends on a partial word. That word holds its valid bytes in the low-order positions. A byte-valid count, captured with every push, tells the reader how many bytes of the word are valid. The block stops sampling while the FIFO reports full and continues once space frees, so it never pushes into a full FIFO.

Top module: `rxo_req_ctrl`

## Requirements
- R1: After reset, `todo_cnt` is 0, `word_push` is 0, `byte_valid` is 0 and `clk_run` is 0.
- R2: A write of a nonzero value with `req_we` loads `todo_cnt` and raises `clk_run` on the next cycle. A write of 0 changes nothing, and `clk_run` stays low while `todo_cnt` is 0.
- R3: A nonzero write while bytes are still outstanding adds the new value to `todo_cnt`. The sum saturates at 65535.
- R4: While `clk_run` is high, each cycle with `shift_tick` high samples `sdi`, most significant bit first. Every eighth sample lowers `todo_cnt` by 1.
- R5: After 32 samples the block pushes a full word. The first received byte sits in bits 31:24 and `byte_valid` reads 4.
- R6: When the count reaches 0 after n bytes (n from 1 to 3) of a word, the block pushes a partial word. It is right-aligned: the first byte is in bits 8n-1:8n-8, the bits above are 0, and `byte_valid` reads n.
- R7: While `fifo_full` is high, `clk_run` is low and ticks are neither sampled nor counted, so no push follows a full cycle. Sampling resumes when `fifo_full` falls.
- R8: `word_push` is a one-cycle pulse on the edge that takes a word's final bit. `word_data` and `byte_valid` then hold until the next push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_we | input | 1 | Write strobe for the byte request |
| req_bytes | input | 16 | Number of bytes to receive |
| shift_tick | input | 1 | One-cycle tick from the baud generator |
| sdi | input | 1 | Serial receive data |
| fifo_full | input | 1 | Receive FIFO has no free entry |
| clk_run | output | 1 | Shift clock enabled (bytes outstanding and FIFO not full) |
| word_data | output | 32 | Packed receive word |
| word_push | output | 1 | One-cycle push strobe for `word_data` |
| todo_cnt | output | 16 | Bytes still to receive |
| byte_valid | output | 3 | Valid bytes in the last pushed word |

## Verification
A request write shows up in `todo_cnt` and `clk_run` one cycle after the write edge. Each sampled tick updates the shift state on that same edge. The eighth tick of a byte lowers `todo_cnt` at that edge, and the final tick of a word raises `word_push` with its data and byte count at that edge as well. The bench drives each input on a falling edge and reads the results on the next falling edge. Every check therefore looks at the first cycle in which a result is due. A one-cycle push is caught within the tick that produced it.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  parameter int unsigned RXO_CNT_W      = 16;
  parameter int unsigned RXO_WORD_BYTES = 4;
  localparam int unsigned RXO_WORD_W    = 8 * RXO_WORD_BYTES;
  localparam int unsigned RXO_BV_W      = $clog2(RXO_WORD_BYTES + 1);
  localparam int unsigned RXO_BIDX_W    = $clog2(RXO_WORD_BYTES);
endpackage

// File: rtl/rxo_rst_sync.sv
module rxo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rxo_shifter.sv
module rxo_shifter
  import rxo_pkg::*;
#(
  parameter int unsigned WORD_BYTES = RXO_WORD_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic                  sdi,
  input  logic                  word_end,
  output logic                  byte_done,
  output logic                  word_full,
  output logic [8*WORD_BYTES-1:0] word_next,
  output logic [$clog2(WORD_BYTES+1)-1:0] bytes_next
);
  localparam int unsigned WW = 8 * WORD_BYTES;
  localparam int unsigned BI = $clog2(WORD_BYTES);
  localparam int unsigned BV = $clog2(WORD_BYTES + 1);

  logic [2:0]    bit_q, bit_n;
  logic [BI-1:0] byte_q, byte_n;
  logic [WW-1:0] sh_q, sh_n;

  // Decode of the current sample position
  always_comb begin
    byte_done  = take && (bit_q == 3'd7);
    word_full  = byte_done && (byte_q == BI'(WORD_BYTES - 1));
    word_next  = {sh_q[WW-2:0], sdi};
    bytes_next = BV'(byte_q) + BV'(1);
  end

  // Next state: shift in, restart with a cleared word after a push
  always_comb begin
    bit_n  = bit_q;
    byte_n = byte_q;
    sh_n   = sh_q;
    if (take) begin
      bit_n = bit_q + 3'd1;
      if (word_end) begin
        byte_n = '0;
        sh_n   = '0;
      end else begin
        sh_n = word_next;
        if (byte_done) byte_n = byte_q + BI'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      byte_q <= '0;
      sh_q   <= '0;
    end else if (take) begin
      bit_q  <= bit_n;
      byte_q <= byte_n;
      sh_q   <= sh_n;
    end
  end
endmodule

// File: rtl/rxo_todo.sv
module rxo_todo
  import rxo_pkg::*;
#(
  parameter int unsigned CNT_W = RXO_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_we,
  input  logic [CNT_W-1:0] add_val,
  input  logic             dec,
  output logic [CNT_W-1:0] todo_q,
  output logic             last
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] todo_n;
  logic             en;

  // Add the request and take away one finished byte, saturating on top
  always_comb begin
    sum    = {1'b0, todo_q} + (add_we ? {1'b0, add_val} : '0) - {{CNT_W{1'b0}}, dec};
    todo_n = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    en     = add_we || dec;
    last   = dec && (todo_n == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  todo_q <= '0;
    else if (en) todo_q <= todo_n;
  end
endmodule

// File: rtl/rxo_word_reg.sv
module rxo_word_reg
  import rxo_pkg::*;
#(
  parameter int unsigned WW = RXO_WORD_W,
  parameter int unsigned BV = RXO_BV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_in,
  input  logic [WW-1:0] data_in,
  input  logic [BV-1:0] bv_in,
  output logic          push_q,
  output logic [WW-1:0] data_q,
  output logic [BV-1:0] bv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) push_q <= 1'b0;
    else        push_q <= push_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bv_q   <= '0;
    end else if (push_in) begin
      data_q <= data_in;
      bv_q   <= bv_in;
    end
  end
endmodule

// File: rtl/rxo_req_ctrl.sv
module rxo_req_ctrl
  import rxo_pkg::*;
#(
  parameter int unsigned CNT_W      = RXO_CNT_W,
  parameter int unsigned WORD_BYTES = RXO_WORD_BYTES,
  localparam int unsigned WW        = 8 * WORD_BYTES,
  localparam int unsigned BV        = $clog2(WORD_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_we,
  input  logic [CNT_W-1:0] req_bytes,
  input  logic             shift_tick,
  input  logic             sdi,
  input  logic             fifo_full,
  output logic             clk_run,
  output logic [WW-1:0]    word_data,
  output logic             word_push,
  output logic [CNT_W-1:0] todo_cnt,
  output logic [BV-1:0]    byte_valid
);
  logic          rst_sync_n;
  logic          take, byte_done, word_full, last, word_end;
  logic [WW-1:0] word_next;
  logic [BV-1:0] bytes_next;

  rxo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Clock runs only with bytes owed and room downstream
  always_comb begin
    clk_run  = (todo_cnt != '0) && !fifo_full;
    take     = clk_run && shift_tick;
    word_end = word_full || last;
  end

  rxo_shifter #(.WORD_BYTES(WORD_BYTES)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .take       (take),
    .sdi        (sdi),
    .word_end   (word_end),
    .byte_done  (byte_done),
    .word_full  (word_full),
    .word_next  (word_next),
    .bytes_next (bytes_next)
  );

  rxo_todo #(.CNT_W(CNT_W)) u_todo (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .add_we  (req_we),
    .add_val (req_bytes),
    .dec     (byte_done),
    .todo_q  (todo_cnt),
    .last    (last)
  );

  rxo_word_reg #(.WW(WW), .BV(BV)) u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push_in (word_end),
    .data_in (word_next),
    .bv_in   (bytes_next),
    .push_q  (word_push),
    .data_q  (word_data),
    .bv_q    (byte_valid)
  );
endmodule

// File: rtl/rxo_req_ctrl_chk.sv
module rxo_req_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_we,
  input logic        fifo_full,
  input logic        clk_run,
  input logic        word_push,
  input logic [15:0] todo_cnt,
  input logic [2:0]  byte_valid
);
  a_r2_idle_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (todo_cnt == 16'd0) |-> !clk_run);

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_we) |-> (todo_cnt <= $past(todo_cnt)) &&
                      ({1'b0, todo_cnt} + 17'd1 >= {1'b0, $past(todo_cnt)}));

  a_r5_bv_range: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> (byte_valid >= 3'd1) && (byte_valid <= 3'd4));

  a_r6_partial_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (word_push && byte_valid != 3'd4) |-> (todo_cnt == 16'd0));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> !$past(fifo_full));

  a_r7_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fifo_full) && !$past(req_we)) |-> (todo_cnt == $past(todo_cnt)));

  a_r8_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |=> !word_push);
endmodule

bind rxo_req_ctrl rxo_req_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_we     (req_we),
  .fifo_full  (fifo_full),
  .clk_run    (clk_run),
  .word_push  (word_push),
  .todo_cnt   (todo_cnt),
  .byte_valid (byte_valid)
);

// File: tb/tb_rxo_req_ctrl.sv
module tb_rxo_req_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_we = 1'b0;
  logic [15:0] req_bytes = '0;
  logic        shift_tick = 1'b0;
  logic        sdi = 1'b0;
  logic        fifo_full = 1'b0;
  logic        clk_run, word_push;
  logic [31:0] word_data;
  logic [15:0] todo_cnt;
  logic [2:0]  byte_valid;

  int n_chk = 0, n_fail = 0, ncap = 0, cyc = 0;
  logic [31:0] cap_w [8];
  logic [2:0]  cap_bv [8];

  always #2 clk = ~clk;

  rxo_req_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_bytes(req_bytes),
    .shift_tick(shift_tick), .sdi(sdi), .fifo_full(fifo_full),
    .clk_run(clk_run), .word_data(word_data), .word_push(word_push),
    .todo_cnt(todo_cnt), .byte_valid(byte_valid)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_we = 0; shift_tick = 0; fifo_full = 0; sdi = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ncap = 0;
  endtask

  task automatic write_req(input logic [15:0] v);
    req_we = 1'b1; req_bytes = v;
    @(negedge clk);
    req_we = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    sdi = b; shift_tick = 1'b1;
    @(negedge clk);
    shift_tick = 1'b0;
    if (word_push && ncap < 8) begin
      cap_w[ncap] = word_data; cap_bv[ncap] = byte_valid; ncap++;
    end
    @(negedge clk);
    chk(!word_push, "R8 push lasts one cycle", 32'(word_push), 0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic t_reset();
    do_reset();
    chk(todo_cnt == 0, "R1 todo after reset", 32'(todo_cnt), 0);
    chk(!word_push && !clk_run, "R1 push/run after reset", {word_push, clk_run}, 0);
    chk(byte_valid == 0, "R1 byte_valid after reset", 32'(byte_valid), 0);
  endtask

  task automatic t_zero_write();
    write_req(16'd0);
    chk(todo_cnt == 0, "R2 zero write ignored", 32'(todo_cnt), 0);
    chk(!clk_run, "R2 no clock when idle", 32'(clk_run), 0);
    send_byte(8'hFF);
    chk(ncap == 0, "R2 idle ticks make no push", ncap, 0);
    chk(todo_cnt == 0, "R2 idle ticks keep count", 32'(todo_cnt), 0);
  endtask

  task automatic t_full_word();
    ncap = 0;
    write_req(16'd4);
    chk(todo_cnt == 4, "R2 request loads count", 32'(todo_cnt), 4);
    chk(clk_run, "R2 clock starts", 32'(clk_run), 1);
    send_byte(8'hA1);
    chk(todo_cnt == 3, "R4 one byte decrements", 32'(todo_cnt), 3);
    send_byte(8'hB2); send_byte(8'hC3);
    chk(ncap == 0, "R4 no push mid word", ncap, 0);
    send_byte(8'hD4);
    chk(ncap == 1, "R5 one full word pushed", ncap, 1);
    chk(cap_w[0] == 32'hA1B2C3D4, "R5 full word data", cap_w[0], 32'hA1B2C3D4);
    chk(cap_bv[0] == 3'd4, "R5 byte_valid 4", 32'(cap_bv[0]), 4);
    chk(todo_cnt == 0 && !clk_run, "R4 count done, clock stops", {todo_cnt, 15'd0, clk_run}, 0);
  endtask

  task automatic t_partial(input int n);
    logic [31:0] exp;
    ncap = 0; exp = '0;
    write_req(16'(4 + n));
    for (int i = 0; i < 4 + n; i++) begin
      send_byte(8'(8'h11 * (i + 1)));
      if (i >= 4) exp = {exp[23:0], 8'(8'h11 * (i + 1))};
    end
    chk(ncap == 2, "R6 two pushes", ncap, 2);
    chk(cap_w[0] == 32'h11223344, "R5 first word", cap_w[0], 32'h11223344);
    chk(cap_w[1] == exp, "R6 partial word right aligned", cap_w[1], exp);
    chk(cap_bv[1] == 3'(n), "R6 partial byte_valid", 32'(cap_bv[1]), n);
    repeat (3) @(negedge clk);
    chk(word_data == exp && byte_valid == 3'(n), "R8 outputs hold after push", word_data, exp);
  endtask

  task automatic t_pause();
    ncap = 0;
    write_req(16'd2);
    send_byte(8'h5A);
    fifo_full = 1'b1;
    @(negedge clk);
    chk(!clk_run, "R7 clock off while full", 32'(clk_run), 0);
    send_byte(8'hFF);
    chk(todo_cnt == 1, "R7 count held while full", 32'(todo_cnt), 1);
    chk(ncap == 0, "R7 no push while full", ncap, 0);
    fifo_full = 1'b0;
    @(negedge clk);
    send_byte(8'h3C);
    chk(ncap == 1 && cap_w[0] == 32'h00005A3C, "R7 resumes after full", cap_w[0], 32'h00005A3C);
  endtask

  task automatic t_add_busy();
    ncap = 0;
    write_req(16'd2);
    send_byte(8'h01);
    write_req(16'd3);
    chk(todo_cnt == 4, "R3 busy write adds", 32'(todo_cnt), 4);
    send_byte(8'h02); send_byte(8'h03); send_byte(8'h04); send_byte(8'h05);
    chk(ncap == 2 && cap_w[0] == 32'h01020304, "R3 added bytes fill word", cap_w[0], 32'h01020304);
    chk(cap_w[1] == 32'h00000005 && cap_bv[1] == 3'd1, "R6 single byte tail", cap_w[1], 32'h5);
    write_req(16'hFFFF);
    write_req(16'h0010);
    chk(todo_cnt == 16'hFFFF, "R3 saturates", 32'(todo_cnt), 32'hFFFF);
  endtask

  initial begin
    t_reset();
    t_zero_write();
    t_full_word();
    t_partial(1);
    t_partial(2);
    t_partial(3);
    t_pause();
    t_add_busy();
    do_reset();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end
endmodule